// File: doc/BRIEF.md
# Interrupt-Line to Mailbox-Write Bridge

This block sits between a set of level-sensitive interrupt wires coming from external peripherals and the memory fabric of a multi-cluster chip. Instead of wiring each interrupt into a controller, it turns every interrupt event into one posted write aimed at a mailbox register. The address of that mailbox picks both the cluster and the core that will take the interrupt, so software can steer any peripheral interrupt to any core by reprogramming an address.

Each input line owns a window of four word registers: a target address, an address extension, a read-only status word and an enable. When an enabled line rises, or when a line that is already high gets enabled, the bridge marks that line pending. A single write master then serves the pending lines one at a time, lowest index first. It drives the programmed address, extension and the line's index as data, and holds them until the fabric acknowledges.

Top module: `irq_mailbox_bridge`

## Requirements
- R1: After reset every enable is 0, no line is pending (status bit 1 reads 0 for every line) and `wrReq` is low.
- R2: Line n's window starts at word address 4*n. Word 0 of the window holds the target address, word 1 the extension (only the low 8 bits are stored; upper bits read as 0) and word 3 the enable in bit 0. Words 0, 1 and 3 read back what was written.
- R3: Word 2 of a window reads the raw input level in bit 0 and the pending flag in bit 1, with all other bits 0. Writes to word 2 have no effect.
- R4: A rising edge on an enabled line produces one write carrying that line's target address, its extension and the line index as data. `wrReq` rises at the second clock edge that sees the line high: the first edge sets pending, the second launches.
- R5: A disabled line never causes a write. An edge seen while disabled is forgotten, so a later enable while the line is low yields nothing. Clearing the enable of a pending line withdraws its pending write.
- R6: Setting the enable of a line whose input is already high makes it pending and produces one write.
- R7: When several lines are pending, the lowest index is launched first and the others stay pending until their turn.
- R8: While `wrReq` is high and `wrAck` is low, `wrReq`, `wrAddr`, `wrExt` and `wrData` hold steady. `wrReq` falls at the clock edge that samples `wrAck` high. A new write can launch no earlier than the next edge.
- R9: A line held high produces no further writes. A new rising edge on a line that is already pending merges with the existing request into one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | NUM_IN (32) | Level interrupt lines, bit n is line n |
| regAddr | input | IDX_W+2 (7) | Word address into the register windows |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| wrReq | output | 1 | Mailbox write request |
| wrAddr | output | ADDR_W (32) | Mailbox target address |
| wrExt | output | EXT_W (8) | Address extension bits |
| wrData | output | 32 | Write data, the index of the served line |
| wrAck | input | 1 | Write accepted by the fabric |

## Verification
An input change driven between edges is registered as pending at the next edge, and `wrReq` with its payload appears one edge after that. An acknowledge drops the request at the edge that samples it. Register writes take effect at the edge after the strobe, while reads are combinational on `regAddr`. The bench keeps a reference model that advances on each rising edge from the same inputs. It compares request and payload at every falling edge, so each result is checked in the cycle it is due. Directed checks sample the request exactly one and two edges after a rise, and they check the order of the acknowledged-write log after each scenario.

// File: rtl/irqmb_pkg.sv
package irqmb_pkg;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_BUSY = 1'b1
  } ctl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;   // latch payload of granted line, clear its pending flag
    logic retire;   // outstanding write acknowledged
  } ctl_strobe_t;

  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_EXT  = 2'd1;
  localparam logic [1:0] FLD_STAT = 2'd2;
  localparam logic [1:0] FLD_MASK = 2'd3;

  localparam int REG_DW = 32;

endpackage

// File: rtl/irqmb_prio_enc.sv
module irqmb_prio_enc #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] grantIdx,
  output logic             anyReq
);

  logic [N:0] lowerAny;
  assign lowerAny[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant[g]        = req[g] & ~lowerAny[g];
    assign lowerAny[g + 1] = lowerAny[g] | req[g];
  end

  assign anyReq = lowerAny[N];

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) grantIdx = grantIdx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/irqmb_ctrl.sv
module irqmb_ctrl
  import irqmb_pkg::*;
#(
  parameter int NUM_IN = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] pend,
  input  logic              wrAck,
  output ctl_strobe_t       strobe,
  output logic [NUM_IN-1:0] grant,
  output logic [IDX_W-1:0]  grantIdx,
  output logic              wrReq
);

  ctl_state_e state, stateNext;
  logic anyPend;

  irqmb_prio_enc #(.N(NUM_IN), .IDX_W(IDX_W)) u_prio (
    .req      (pend),
    .grant    (grant),
    .grantIdx (grantIdx),
    .anyReq   (anyPend)
  );

  always_comb begin
    strobe.launch = (state == CTL_IDLE) && anyPend;
    strobe.retire = (state == CTL_BUSY) && wrAck;
    stateNext = state;
    if (strobe.launch)      stateNext = CTL_BUSY;
    else if (strobe.retire) stateNext = CTL_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= CTL_IDLE;
    else       state <= stateNext;
  end

  assign wrReq = (state == CTL_BUSY);

  // R7: the launched line is the single lowest pending one
  a_r7_lowest_first: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |-> ($countones(grant) == 1) && ((pend & (grant - NUM_IN'(1))) == '0));

  // R8: request persists until acknowledged
  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAck |=> wrReq);

  // R8: request drops at the acknowledging edge
  a_r8_drop_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && wrAck |=> !wrReq);

endmodule

// File: rtl/irqmb_datapath.sv
module irqmb_datapath
  import irqmb_pkg::*;
#(
  parameter int NUM_IN = 32,
  parameter int ADDR_W = 32,
  parameter int EXT_W  = 8,
  parameter int IDX_W  = 5,
  parameter int REG_AW = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IN-1:0]  irqIn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [REG_DW-1:0]  regWrData,
  output logic [REG_DW-1:0]  regRdData,
  input  ctl_strobe_t        strobe,
  input  logic [NUM_IN-1:0]  grant,
  input  logic [IDX_W-1:0]   grantIdx,
  output logic [NUM_IN-1:0]  pend,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [EXT_W-1:0]   wrExt,
  output logic [REG_DW-1:0]  wrData
);

  logic [ADDR_W-1:0] tgtAddr [NUM_IN];
  logic [EXT_W-1:0]  tgtExt  [NUM_IN];
  logic [NUM_IN-1:0] enMask, irqPrev;
  logic [NUM_IN-1:0] winHit, maskWr, maskNext, setEv, clrEv, pendNext;

  logic [IDX_W-1:0] selIdx;
  logic [1:0]       selFld;
  logic             selValid;

  assign selIdx   = regAddr[REG_AW-1:2];
  assign selFld   = regAddr[1:0];
  assign selValid = int'(selIdx) < NUM_IN;

  // per-line write decode and pending update
  for (genvar g = 0; g < NUM_IN; g++) begin : g_line
    assign winHit[g]   = regWrEn && selValid && (selIdx == IDX_W'(g));
    assign maskWr[g]   = winHit[g] && (selFld == FLD_MASK);
    assign maskNext[g] = maskWr[g] ? regWrData[0] : enMask[g];
    assign setEv[g]    = irqIn[g] &
                         ((enMask[g] & ~irqPrev[g]) | (maskWr[g] & regWrData[0] & ~enMask[g]));
    assign clrEv[g]    = strobe.launch & grant[g];
    assign pendNext[g] = ((pend[g] & ~clrEv[g]) | setEv[g]) & maskNext[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask  <= '0;
      pend    <= '0;
      irqPrev <= '0;
      for (int i = 0; i < NUM_IN; i++) begin
        tgtAddr[i] <= '0;
        tgtExt[i]  <= '0;
      end
    end else begin
      enMask  <= maskNext;
      pend    <= pendNext;
      irqPrev <= irqIn;
      for (int i = 0; i < NUM_IN; i++) begin
        if (winHit[i] && selFld == FLD_ADDR) tgtAddr[i] <= regWrData[ADDR_W-1:0];
        if (winHit[i] && selFld == FLD_EXT)  tgtExt[i]  <= regWrData[EXT_W-1:0];
      end
    end
  end

  // outgoing payload, captured at launch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddr <= '0;
      wrExt  <= '0;
      wrData <= '0;
    end else if (strobe.launch) begin
      wrAddr <= tgtAddr[grantIdx];
      wrExt  <= tgtExt[grantIdx];
      wrData <= REG_DW'(grantIdx);
    end
  end

  // register read mux
  always_comb begin
    regRdData = '0;
    if (selValid) begin
      unique case (selFld)
        FLD_ADDR: regRdData = REG_DW'(tgtAddr[selIdx]);
        FLD_EXT:  regRdData = REG_DW'(tgtExt[selIdx]);
        FLD_STAT: regRdData = REG_DW'({pend[selIdx], irqIn[selIdx]});
        default:  regRdData = REG_DW'(enMask[selIdx]);
      endcase
    end
  end

  // R5: no line is pending while disabled
  a_r5_pend_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (pend & ~enMask) == '0);

  // R4: a launch always consumes a pending line
  a_r4_launch_has_pend: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |-> (grant & pend) != '0);

  // R4: a launched line's flag is gone at the next edge unless re-armed by a fresh event
  a_r4_launch_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch && ((setEv & grant) == '0) |=> (pend & $past(grant)) == '0);

endmodule

// File: rtl/irq_mailbox_bridge.sv
module irq_mailbox_bridge
  import irqmb_pkg::*;
#(
  parameter int NUM_IN = 32,
  parameter int ADDR_W = 32,
  parameter int EXT_W  = 8,
  localparam int IDX_W  = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int REG_AW = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IN-1:0]  irqIn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               wrReq,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [EXT_W-1:0]   wrExt,
  output logic [31:0]        wrData,
  input  logic               wrAck
);

  ctl_strobe_t       strobe;
  logic [NUM_IN-1:0] pend, grant;
  logic [IDX_W-1:0]  grantIdx;

  irqmb_ctrl #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pend     (pend),
    .wrAck    (wrAck),
    .strobe   (strobe),
    .grant    (grant),
    .grantIdx (grantIdx),
    .wrReq    (wrReq)
  );

  irqmb_datapath #(
    .NUM_IN (NUM_IN),
    .ADDR_W (ADDR_W),
    .EXT_W  (EXT_W),
    .IDX_W  (IDX_W),
    .REG_AW (REG_AW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobe    (strobe),
    .grant     (grant),
    .grantIdx  (grantIdx),
    .pend      (pend),
    .wrAddr    (wrAddr),
    .wrExt     (wrExt),
    .wrData    (wrData)
  );

  // R8: payload is steady while waiting for acknowledge
  a_r8_payload_stable: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAck |=> $stable(wrAddr) && $stable(wrExt) && $stable(wrData));

endmodule

// File: tb/tb_irq_mailbox_bridge.sv
module tb_irq_mailbox_bridge;

  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [N-1:0] irqIn = '0;
  logic [6:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        wrReq;
  logic [31:0] wrAddr;
  logic [7:0]  wrExt;
  logic [31:0] wrData;
  logic        wrAck = 1'b0;

  int checks = 0;
  int errors = 0;
  int ackDelay = 0;
  int logQ[$];

  irq_mailbox_bridge dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .wrReq(wrReq), .wrAddr(wrAddr),
    .wrExt(wrExt), .wrData(wrData), .wrAck(wrAck)
  );

  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  logic [31:0] mAddr [N];
  logic [7:0]  mExt  [N];
  bit          mMask [N];
  bit          mPend [N];
  bit          mPrev [N];
  bit          mBusy;
  logic [31:0] mOutAddr, mOutData;
  logic [7:0]  mOutExt;

  always @(posedge clk) begin
    int  launch;
    bit  nPend [N];
    bit  nMask [N];
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        mAddr[i] = 0; mExt[i] = 0; mMask[i] = 0; mPend[i] = 0; mPrev[i] = 0;
      end
      mBusy = 0; mOutAddr = 0; mOutExt = 0; mOutData = 0;
    end else begin
      launch = -1;
      if (!mBusy) begin
        for (int i = N - 1; i >= 0; i--) if (mPend[i]) launch = i;
      end
      for (int i = 0; i < N; i++) begin
        bit hitMask, setIt;
        hitMask  = regWrEn && (int'(regAddr[6:2]) == i) && (regAddr[1:0] == 2'd3);
        nMask[i] = hitMask ? regWrData[0] : mMask[i];
        setIt    = irqIn[i] && ((mMask[i] && !mPrev[i]) || (hitMask && regWrData[0] && !mMask[i]));
        nPend[i] = ((mPend[i] && i != launch) || setIt) && nMask[i];
      end
      if (mBusy) begin
        if (wrAck) mBusy = 0;
      end else if (launch >= 0) begin
        mBusy = 1; mOutAddr = mAddr[launch]; mOutExt = mExt[launch]; mOutData = launch;
      end
      if (regWrEn && regAddr[1:0] == 2'd0) mAddr[regAddr[6:2]] = regWrData;
      if (regWrEn && regAddr[1:0] == 2'd1) mExt[regAddr[6:2]]  = regWrData[7:0];
      for (int i = 0; i < N; i++) begin
        mMask[i] = nMask[i]; mPend[i] = nPend[i]; mPrev[i] = irqIn[i];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R4 R8)
  initial forever begin
    @(negedge clk);
    if (rstN) begin
      check(wrReq == mBusy, "R4 R8 wrReq", wrReq, mBusy);
      if (mBusy && wrReq) begin
        check(wrAddr == mOutAddr, "R4 R8 wrAddr", wrAddr, mOutAddr);
        check(wrExt == mOutExt, "R4 R8 wrExt", wrExt, mOutExt);
        check(wrData == mOutData, "R4 R8 wrData", wrData, mOutData);
      end
    end
  end

  // acknowledge responder and write log
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        wrAck = 1'b0; cnt = 0;
      end else if (wrReq && !wrAck) begin
        if (cnt >= ackDelay) begin
          wrAck = 1'b1; logQ.push_back(int'(wrData)); cnt = 0;
        end else cnt++;
      end else wrAck = 1'b0;
    end
  end

  function automatic logic [6:0] ra(input int idx, input int fld);
    return 7'(idx * 4 + fld);
  endfunction

  task automatic regWrite(input int idx, input int fld, input logic [31:0] d);
    @(negedge clk);
    regAddr = ra(idx, fld); regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input int idx, input int fld, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = ra(idx, fld);
    #1;
    check(regRdData == exp, tag, regRdData, exp);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkLog(input int n, input int e0, input int e1, input int e2, input int e3,
                          input string tag);
    int exp [4];
    exp = '{e0, e1, e2, e3};
    check(logQ.size() == n, tag, logQ.size(), n);
    for (int k = 0; k < n && k < logQ.size(); k++) check(logQ[k] == exp[k], tag, logQ[k], exp[k]);
    logQ.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);

    // R1 reset state
    check(wrReq == 1'b0, "R1 wrReq after reset", wrReq, 0);
    regRead(0, 3, 0, "R1 enable line 0");
    regRead(31, 3, 0, "R1 enable line 31");
    regRead(17, 2, 0, "R1 status line 17");

    // R2 program windows
    for (int i = 0; i < N; i++) begin
      regWrite(i, 0, 32'h8000_0000 | (i << 8));
      regWrite(i, 1, 32'(i ^ 8'h5A));
    end
    regRead(5, 0, 32'h8000_0500, "R2 addr line 5");
    regRead(31, 1, 32'(31 ^ 8'h5A), "R2 ext line 31");
    regWrite(6, 1, 32'h0000_01A5);
    regRead(6, 1, 32'h0000_00A5, "R2 ext truncated to 8 bits");
    regWrite(12, 3, 32'h1);
    regRead(12, 3, 32'h1, "R2 enable readback");
    regWrite(12, 3, 32'h0);

    // R3 status is read-only
    regWrite(6, 2, 32'hFFFF_FFFF);
    regRead(6, 2, 0, "R3 status write ignored");
    regRead(6, 3, 0, "R3 status write left enable alone");

    // R5 disabled line
    @(negedge clk); irqIn[6] = 1'b1;
    regRead(6, 2, 32'h1, "R3 raw level in bit 0");
    waitCycles(5);
    @(negedge clk); irqIn[6] = 1'b0;
    regWrite(6, 3, 32'h1);
    waitCycles(6);
    regRead(6, 2, 0, "R5 stale edge not pending");
    checkLog(0, 0, 0, 0, 0, "R5 no write from disabled line");

    // R6 enable while high
    @(negedge clk); irqIn[10] = 1'b1;
    waitCycles(3);
    regWrite(10, 3, 32'h1);
    waitCycles(6);
    checkLog(1, 10, 0, 0, 0, "R6 enable while high");

    // R4 latency and payload
    regWrite(3, 3, 32'h1);
    ackDelay = 4;
    @(negedge clk); irqIn[3] = 1'b1;
    @(negedge clk);
    check(wrReq == 1'b0, "R4 no request after first edge", wrReq, 0);
    @(negedge clk);
    check(wrReq == 1'b1, "R4 request after second edge", wrReq, 1);
    check(wrAddr == 32'h8000_0300, "R4 address", wrAddr, 32'h8000_0300);
    check(wrExt == 8'(3 ^ 8'h5A), "R4 extension", wrExt, 3 ^ 8'h5A);
    check(wrData == 32'd3, "R4 data is index", wrData, 3);
    waitCycles(8);
    // R9 held high gives nothing more
    waitCycles(10);
    checkLog(1, 3, 0, 0, 0, "R9 held level gives one write");
    @(negedge clk); irqIn[3] = 1'b0;

    // R9 merge while pending
    regWrite(0, 3, 32'h1);
    ackDelay = 8;
    @(negedge clk); irqIn[0] = 1'b1;
    waitCycles(2);
    @(negedge clk); irqIn[3] = 1'b1;
    waitCycles(2);
    @(negedge clk); irqIn[3] = 1'b0;
    waitCycles(1);
    @(negedge clk); irqIn[3] = 1'b1;
    waitCycles(25);
    checkLog(2, 0, 3, 0, 0, "R9 merged edges give one write");
    @(negedge clk); irqIn[0] = 1'b0; irqIn[3] = 1'b0;

    // R7 priority order, R8 back to back
    regWrite(1, 3, 32'h1);
    regWrite(2, 3, 32'h1);
    regWrite(9, 3, 32'h1);
    regWrite(31, 3, 32'h1);
    ackDelay = 1;
    @(negedge clk); irqIn[31] = 1'b1; irqIn[9] = 1'b1; irqIn[2] = 1'b1; irqIn[1] = 1'b1;
    waitCycles(2);
    regRead(31, 2, 32'h3, "R7 highest index still pending");
    waitCycles(20);
    checkLog(4, 1, 2, 9, 31, "R7 lowest index first");
    @(negedge clk); irqIn = '0;

    // R5 disable withdraws pending write
    regWrite(20, 3, 32'h1);
    regWrite(21, 3, 32'h1);
    ackDelay = 6;
    @(negedge clk); irqIn[20] = 1'b1; irqIn[21] = 1'b1;
    waitCycles(3);
    regRead(21, 2, 32'h3, "R3 pending bit set");
    regWrite(21, 3, 32'h0);
    regRead(21, 2, 32'h1, "R5 pending withdrawn by disable");
    waitCycles(15);
    checkLog(1, 20, 0, 0, 0, "R5 disabled line not written");
    @(negedge clk); irqIn = '0;
    waitCycles(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule